// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps two state bits for each of a small set of interrupt sources: a pending bit that says the source is eligible to be serviced, and an active bit that says its handler is running. A source becomes pending either because its hardware request line is high or because software issues a trigger that names its number. The two paths have exactly the same effect: a software trigger only marks the source pending and never forces a branch into a handler.

The tracker offers the core the lowest-numbered pending source as its entry candidate. The core reports each instruction boundary. Entry happens only on a boundary cycle and only while no source is active. In that cycle the candidate's pending bit clears and its active bit sets. An exception-return pulse that carries a source number clears that source's active bit. Software can also clear pending bits directly. Nested service is not supported, so at most one source is active at any time.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset, all pending and active bits are 0, `cand_valid` is 0 and `enter` is 0.
- R2: A high `hw_req[i]` in a cycle sets `pending[i]` at the next clock edge.
- R3: A software trigger (`sw_trig` high with number `sw_num`) sets only `pending[sw_num]` at the next edge, exactly like a hardware line. It does not cause entry unless `at_boundary` is also high.
- R4: A hardware request and a software trigger for the same source in the same cycle produce one pending bit, with the same result as either one alone.
- R5: `cand_id` is the lowest index whose pending bit is set, and is 0 when none is set. `cand_valid` is 1 exactly when some pending bit is set and no active bit is set.
- R6: `enter` is high exactly when `at_boundary` and `cand_valid` are both high. At that clock edge, bit `cand_id` moves from pending to active.
- R7: While any source is active, no entry is granted (`cand_valid` and `enter` stay 0), and at most one active bit is ever set.
- R8: A return pulse (`ret_valid` high with number `ret_num`) clears `active[ret_num]` at the next edge. It changes no other active bit and no pending bit.
- R9: A request for a source that is already active sets its pending bit again, and that source is taken again after its return.
- R10: `clr_pend[i]` clears `pending[i]` at the next edge. A request for the same source in the same cycle wins over the clear.
- R11: A request for the source being entered in that same cycle leaves its pending bit set after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | N_SRC | Hardware request lines, one per source |
| sw_trig | input | 1 | Software trigger strobe |
| sw_num | input | IW | Source number carried by the software trigger |
| clr_pend | input | N_SRC | Per-source pending clear |
| at_boundary | input | 1 | Core is at an instruction boundary this cycle |
| ret_valid | input | 1 | Exception-return pulse |
| ret_num | input | IW | Source number of the returning handler |
| enter | output | 1 | Entry granted this cycle |
| cand_valid | output | 1 | An entry candidate exists and nothing is active |
| cand_id | output | IW | Lowest-numbered pending source |
| pending | output | N_SRC | Pending bits |
| active | output | N_SRC | Active bits |

## Verification
The bench builds the tracker with N_SRC = 8, so IW is 3. With this setting the test can drive both the lowest source (0) and the highest (7) as candidates. It can also set a higher-numbered bit while a lower one is pending, which exercises the priority order. The stimulus table chains one sequence of states through request merging, entry blocked by an active source, re-pending of an active source, returns that name a source that is not active, and contested set and clear cycles.

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_req,
  input  logic             sw_trig,
  input  logic [IW-1:0]    sw_num,
  input  logic [N_SRC-1:0] clr_pend,
  input  logic             at_boundary,
  input  logic             ret_valid,
  input  logic [IW-1:0]    ret_num,
  output logic             enter,
  output logic             cand_valid,
  output logic [IW-1:0]    cand_id,
  output logic [N_SRC-1:0] pending,
  output logic [N_SRC-1:0] active
);

  logic [N_SRC-1:0] set_mask, take_mask, ret_mask;
  logic             any_pend;

  assign set_mask  = hw_req | (sw_trig ? (N_SRC'(1) << sw_num) : '0);
  assign ret_mask  = ret_valid ? (N_SRC'(1) << ret_num) : '0;
  assign any_pend  = |pending;
  assign cand_valid = any_pend && (active == '0);
  assign enter     = at_boundary && cand_valid;
  assign take_mask = enter ? (N_SRC'(1) << cand_id) : '0;

  always_comb begin
    cand_id = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pending[i]) cand_id = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
    end else begin
      pending <= (pending & ~clr_pend & ~take_mask) | set_mask;
      active  <= (active & ~ret_mask) | take_mask;
    end
  end

endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] hw_req,
  input logic             at_boundary,
  input logic             ret_valid,
  input logic [IW-1:0]    ret_num,
  input logic             enter,
  input logic             cand_valid,
  input logic [IW-1:0]    cand_id,
  input logic [N_SRC-1:0] pending,
  input logic [N_SRC-1:0] active
);

  p_hw_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req != '0) |=> ((pending & $past(hw_req)) == $past(hw_req)));

  p_cand_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> pending[cand_id]);

  p_enter_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> (at_boundary && active == '0));

  p_entry_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (active[$past(cand_id)] && $countones(active) == 1));

  p_no_entry_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |-> (!cand_valid && !enter));

  p_single_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active));

  p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && active[ret_num]) |=> !active[$past(ret_num)]);

endmodule

bind irq_state_tracker irq_state_tracker_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .at_boundary(at_boundary),
  .ret_valid(ret_valid), .ret_num(ret_num), .enter(enter),
  .cand_valid(cand_valid), .cand_id(cand_id), .pending(pending),
  .active(active)
);

// File: tb/irq_state_tracker_tb.sv
module irq_state_tracker_tb;
  localparam int N = 8;
  localparam int IW = 3;

  typedef struct packed {
    logic [7:0] hw;
    logic       swv;
    logic [2:0] swn;
    logic [7:0] clr;
    logic       bnd;
    logic       rv;
    logic [2:0] rn;
    logic       e_enter;
    logic [7:0] e_pend;
    logic [7:0] e_act;
    logic       e_cv;
    logic [2:0] e_cid;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h20,1'b0,3'd0,8'h00,1'b0,1'b0,3'd0, 1'b0,8'h20,8'h00,1'b1,3'd5}, // R2
    '{8'h00,1'b1,3'd2,8'h00,1'b0,1'b0,3'd0, 1'b0,8'h24,8'h00,1'b1,3'd2}, // R3 R5
    '{8'h08,1'b1,3'd3,8'h00,1'b0,1'b0,3'd0, 1'b0,8'h2C,8'h00,1'b1,3'd2}, // R4
    '{8'h00,1'b0,3'd0,8'h00,1'b1,1'b0,3'd0, 1'b1,8'h28,8'h04,1'b0,3'd3}, // R6
    '{8'h00,1'b0,3'd0,8'h00,1'b1,1'b0,3'd0, 1'b0,8'h28,8'h04,1'b0,3'd3}, // R7
    '{8'h00,1'b1,3'd2,8'h00,1'b0,1'b0,3'd0, 1'b0,8'h2C,8'h04,1'b0,3'd2}, // R9
    '{8'h00,1'b0,3'd0,8'h00,1'b0,1'b1,3'd5, 1'b0,8'h2C,8'h04,1'b0,3'd2}, // R8 not active
    '{8'h00,1'b0,3'd0,8'h00,1'b0,1'b1,3'd2, 1'b0,8'h2C,8'h00,1'b1,3'd2}, // R8
    '{8'h00,1'b0,3'd0,8'h00,1'b1,1'b0,3'd0, 1'b1,8'h28,8'h04,1'b0,3'd3}, // R9 retaken
    '{8'h08,1'b0,3'd0,8'h08,1'b0,1'b1,3'd2, 1'b0,8'h28,8'h00,1'b1,3'd3}, // R10 set wins
    '{8'h00,1'b0,3'd0,8'h08,1'b0,1'b0,3'd0, 1'b0,8'h20,8'h00,1'b1,3'd5}, // R10
    '{8'h20,1'b0,3'd0,8'h00,1'b1,1'b0,3'd0, 1'b1,8'h20,8'h20,1'b0,3'd5}, // R11
    '{8'h00,1'b0,3'd0,8'h20,1'b0,1'b1,3'd5, 1'b0,8'h00,8'h00,1'b0,3'd0}, // R8 R10
    '{8'h00,1'b1,3'd7,8'h00,1'b0,1'b0,3'd0, 1'b0,8'h80,8'h00,1'b1,3'd7}, // R3
    '{8'h01,1'b0,3'd0,8'h00,1'b1,1'b0,3'd0, 1'b1,8'h01,8'h80,1'b0,3'd0}, // R6
    '{8'h00,1'b0,3'd0,8'h00,1'b0,1'b1,3'd7, 1'b0,8'h01,8'h00,1'b1,3'd0}  // R8 R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] hw_req = '0, clr_pend = '0;
  logic sw_trig = 1'b0, at_boundary = 1'b0, ret_valid = 1'b0;
  logic [IW-1:0] sw_num = '0, ret_num = '0;
  logic enter, cand_valid;
  logic [IW-1:0] cand_id;
  logic [N-1:0] pending, active;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_state_tracker #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_trig(sw_trig),
    .sw_num(sw_num), .clr_pend(clr_pend), .at_boundary(at_boundary),
    .ret_valid(ret_valid), .ret_num(ret_num), .enter(enter),
    .cand_valid(cand_valid), .cand_id(cand_id), .pending(pending),
    .active(active)
  );

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic idle_inputs();
    hw_req = '0; clr_pend = '0; sw_trig = 1'b0; sw_num = '0;
    at_boundary = 1'b0; ret_valid = 1'b0; ret_num = '0;
  endtask

  task automatic check_reset_state();
    chk("R1 pending", 32'(pending), 32'h0);
    chk("R1 active", 32'(active), 32'h0);
    chk("R1 cand_valid", 32'(cand_valid), 32'h0);
    chk("R1 enter", 32'(enter), 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    #1 check_reset_state();
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      hw_req = VEC[k].hw; sw_trig = VEC[k].swv; sw_num = VEC[k].swn;
      clr_pend = VEC[k].clr; at_boundary = VEC[k].bnd;
      ret_valid = VEC[k].rv; ret_num = VEC[k].rn;
      #1 chk($sformatf("R6 R3 enter step %0d", k), 32'(enter), 32'(VEC[k].e_enter));
      @(posedge clk);
      #1;
      idle_inputs();
      chk($sformatf("pending step %0d (R2 R4 R10 R11)", k), 32'(pending), 32'(VEC[k].e_pend));
      chk($sformatf("active step %0d (R6 R7 R8)", k), 32'(active), 32'(VEC[k].e_act));
      chk($sformatf("R5 cand_valid step %0d", k), 32'(cand_valid), 32'(VEC[k].e_cv));
      chk($sformatf("R5 cand_id step %0d", k), 32'(cand_id), 32'(VEC[k].e_cid));
    end
    // R3: trigger without boundary never enters; enter while active blocked (R7)
    @(negedge clk);
    sw_trig = 1'b1; sw_num = 3'd4;
    #1 chk("R3 no entry without boundary", 32'(enter), 32'h0);
    @(posedge clk); #1 idle_inputs();
    chk("R3 only bit 4 added", 32'(pending), 32'h11);
    // reset mid-run clears everything (R1)
    @(negedge clk);
    at_boundary = 1'b1;
    @(posedge clk); #1 idle_inputs();
    chk("R6 entry of source 0", 32'(active), 32'h01);
    rst_n = 1'b0;
    #1 check_reset_state();
    @(negedge clk); rst_n = 1'b1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule